// File: doc/BRIEF.md
# Message Mailbox with Status and Interrupt Control

This block holds a short queue of 32-bit message words delivered by a producer through a push port and consumed by one processor through a small register window. Reading any address in the data window removes the oldest word. The remaining words shift down one slot, and the slot that empties is refilled with an all-ones invalid marker. A separate peek address returns the oldest word without removing it.

A status word reports the full flag, the empty flag and the current fill level. A config word holds the data-interrupt enable, a pending bit that follows the non-empty state, and sticky error flags. The single interrupt line is high whenever the enable is set and the queue is not empty. A read-only address passes through the status word of a companion mailbox. Only the low eight address bits are decoded, and only full 32-bit accesses take effect.

Top module: `mbx_mailbox`

## Requirements
- R1: A full-word read at any offset from 0x80 to 0x8C returns the oldest word and removes it, so words come out in push order. On an empty queue the read returns 32'hFFFF_FFFF, leaves the queue unchanged and sets config bit 10 (underflow error).
- R2: A full-word read at offset 0x90 returns the oldest word (32'hFFFF_FFFF when empty) and leaves the queue and its level unchanged.
- R3: A read at offset 0x98 returns status: bit 31 is set when the level equals the depth, bit 30 is set when the level is 0, bits 7:0 hold the level, and all other bits are 0.
- R4: After reset the level is 0, config reads 0, status reads 32'h4000_0000, the interrupt is low and every slot holds 32'hFFFF_FFFF.
- R5: A removal shifts the remaining words down one slot and writes 32'hFFFF_FFFF into the vacated top slot, so a drained queue peeks as 32'hFFFF_FFFF.
- R6: Config (offset 0x9C) bit 0 is the data-interrupt enable and bit 4 is data-pending, which equals "queue not empty". The interrupt output equals bit 0 AND bit 4.
- R7: A full-word write to config loads only bit 0 from the write data and clears error bits 8, 9 and 10. An error event in the same cycle is still recorded.
- R8: A push while the queue is full is dropped and sets config bit 9 (overflow error). A push in the same cycle as a removal from a full queue is accepted and sets no error.
- R9: Only address bits 7:0 are decoded. Offset 0xB8 returns the companion mailbox status input unchanged.
- R10: Reads at undecoded offsets and accesses that are not full-word return 0. Such reads remove nothing, and writes to anything other than a full-word config access change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Register byte address; only bits 7:0 are decoded |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_word | input | 1 | High when the access is a full 32-bit access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the read strobe |
| msg_push | input | 1 | Push a message word this cycle |
| msg_data | input | 32 | Message word to push |
| peer_status | input | 32 | Status word of the companion mailbox |
| irq | output | 1 | Level interrupt: data pending and enabled |

## Verification
A wrong level count shows up in the status word at once and, one read later, as a word out of order or a spurious invalid marker in the data window. A slot that is not refilled on a shift stays invisible until the queue drains past it: the peek after the last removal then shows a stale word instead of all ones. This is why the directed tests fill the queue to depth and drain it completely. Error-flag faults appear only on the next config read, so every overflow, underflow and clear scenario reads config straight afterwards. Interrupt faults are visible on the pin in the cycle after the push, removal or enable change that causes them.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

   localparam int unsigned DATA_W = 32;
   localparam int unsigned OFS_W  = 8;
   localparam int unsigned LVL_W  = 8;

   localparam logic [OFS_W-1:0] OFS_WIN_LO = 8'h80;
   localparam logic [OFS_W-1:0] OFS_WIN_HI = 8'h8C;
   localparam logic [OFS_W-1:0] OFS_PEEK   = 8'h90;
   localparam logic [OFS_W-1:0] OFS_STAT   = 8'h98;
   localparam logic [OFS_W-1:0] OFS_CFG    = 8'h9C;
   localparam logic [OFS_W-1:0] OFS_PEER   = 8'hB8;

   localparam int unsigned STAT_FULL_BIT  = 31;
   localparam int unsigned STAT_EMPTY_BIT = 30;
   localparam int unsigned CFG_EN_BIT     = 0;
   localparam int unsigned CFG_PEND_BIT   = 4;
   localparam int unsigned CFG_NOOWN_BIT  = 8;
   localparam int unsigned CFG_OVER_BIT   = 9;
   localparam int unsigned CFG_UNDER_BIT  = 10;

   typedef struct packed {
      logic under;
      logic over;
   } mbx_err_t;

endpackage

// File: rtl/mbx_fifo.sv
module mbx_fifo #(
   parameter int unsigned        DEPTH   = 8,
   parameter int unsigned        WIDTH   = 32,
   parameter logic [WIDTH-1:0]   INVALID = '1,
   localparam int unsigned       CNT_W   = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push_req,
   input  logic [WIDTH-1:0] push_data,
   input  logic             pop_req,
   output logic [WIDTH-1:0] head,
   output logic [CNT_W-1:0] level,
   output logic             full,
   output logic             empty,
   output logic             push_ok,
   output logic             pop_ok
);

   logic [WIDTH-1:0] slot_q [DEPTH];
   logic [WIDTH-1:0] slot_d [DEPTH];
   logic [CNT_W-1:0] level_q;
   logic [CNT_W-1:0] wr_idx;

   assign full    = (level_q == CNT_W'(DEPTH));
   assign empty   = (level_q == '0);
   assign pop_ok  = pop_req & ~empty;
   assign push_ok = push_req & (~full | pop_ok);
   assign wr_idx  = pop_ok ? level_q - 1'b1 : level_q;
   assign head    = slot_q[0];
   assign level   = level_q;

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      logic [WIDTH-1:0] above;
      if (g == DEPTH - 1) begin : g_top
         assign above = INVALID;
      end else begin : g_mid
         assign above = slot_q[g+1];
      end
      assign slot_d[g] = (push_ok && wr_idx == CNT_W'(g)) ? push_data :
                         pop_ok                           ? above     :
                                                            slot_q[g];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         level_q <= '0;
         for (int i = 0; i < DEPTH; i++) slot_q[i] <= INVALID;
      end else begin
         level_q <= level_q + CNT_W'(push_ok) - CNT_W'(pop_ok);
         for (int i = 0; i < DEPTH; i++) slot_q[i] <= slot_d[i];
      end
   end

endmodule

// File: rtl/mbx_regs.sv
module mbx_regs
   import mbx_pkg::*;
#(
   parameter int unsigned        CNT_W   = 4,
   parameter logic [DATA_W-1:0]  INVALID = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd,
   input  logic              wr,
   input  logic              word,
   input  logic [OFS_W-1:0]  ofs,
   input  logic              wdata_en,
   input  logic [DATA_W-1:0] head,
   input  logic [CNT_W-1:0]  level,
   input  logic              full,
   input  logic              empty,
   input  logic              push_drop,
   input  logic [DATA_W-1:0] peer_status,
   output logic              pop_req,
   output logic              cfg_wr,
   output logic              cfg_en,
   output mbx_err_t          err,
   output logic [DATA_W-1:0] rdata,
   output logic              irq
);

   logic     rd_ok;
   logic     in_win;
   logic     en_q;
   mbx_err_t err_q, err_d;
   logic [DATA_W-1:0] stat_w, cfg_w;

   assign rd_ok   = rd & word;
   assign in_win  = (ofs >= OFS_WIN_LO) && (ofs <= OFS_WIN_HI);
   assign pop_req = rd_ok & in_win;
   assign cfg_wr  = wr & word & (ofs == OFS_CFG);

   always_comb begin
      stat_w = '0;
      stat_w[STAT_FULL_BIT]  = full;
      stat_w[STAT_EMPTY_BIT] = empty;
      stat_w[LVL_W-1:0]      = LVL_W'(level);
   end

   always_comb begin
      cfg_w = '0;
      cfg_w[CFG_EN_BIT]    = en_q;
      cfg_w[CFG_PEND_BIT]  = ~empty;
      cfg_w[CFG_NOOWN_BIT] = 1'b0;
      cfg_w[CFG_OVER_BIT]  = err_q.over;
      cfg_w[CFG_UNDER_BIT] = err_q.under;
   end

   always_comb begin
      rdata = '0;
      if (rd_ok) begin
         if (in_win) begin
            rdata = empty ? INVALID : head;
         end else begin
            unique case (ofs)
               OFS_PEEK: rdata = head;
               OFS_STAT: rdata = stat_w;
               OFS_CFG:  rdata = cfg_w;
               OFS_PEER: rdata = peer_status;
               default:  rdata = '0;
            endcase
         end
      end
   end

   always_comb begin
      err_d = cfg_wr ? '0 : err_q;
      if (push_drop)       err_d.over  = 1'b1;
      if (pop_req && empty) err_d.under = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q  <= 1'b0;
         err_q <= '0;
      end else begin
         err_q <= err_d;
         if (cfg_wr) en_q <= wdata_en;
      end
   end

   assign cfg_en = en_q;
   assign err    = err_q;
   assign irq    = en_q & ~empty;

endmodule

// File: rtl/mbx_mailbox.sv
module mbx_mailbox
   import mbx_pkg::*;
#(
   parameter int unsigned       ADDR_W  = 12,
   parameter int unsigned       DEPTH   = 8,
   parameter logic [DATA_W-1:0] INVALID = 32'hFFFF_FFFF,
   localparam int unsigned      CNT_W   = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic              bus_word,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              msg_push,
   input  logic [DATA_W-1:0] msg_data,
   input  logic [DATA_W-1:0] peer_status,
   output logic              irq
);

   if (DEPTH < 1 || DEPTH > 255) begin : g_bad_depth
      $error("mbx_mailbox: DEPTH must be within 1..255");
   end
   if (ADDR_W < OFS_W) begin : g_bad_addr
      $error("mbx_mailbox: ADDR_W must be at least 8");
   end

   logic [DATA_W-1:0] head;
   logic [CNT_W-1:0]  level;
   logic              full, empty, push_ok, pop_ok;
   logic              pop_req, cfg_wr, cfg_en, push_drop;
   mbx_err_t          err;
   logic              unused_bits;

   assign push_drop   = msg_push & ~push_ok;
   assign unused_bits = ^{bus_addr, bus_wdata[DATA_W-1:1], pop_ok};

   mbx_fifo #(
      .DEPTH   (DEPTH),
      .WIDTH   (DATA_W),
      .INVALID (INVALID)
   ) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push_req  (msg_push),
      .push_data (msg_data),
      .pop_req   (pop_req),
      .head      (head),
      .level     (level),
      .full      (full),
      .empty     (empty),
      .push_ok   (push_ok),
      .pop_ok    (pop_ok)
   );

   mbx_regs #(
      .CNT_W   (CNT_W),
      .INVALID (INVALID)
   ) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .rd          (bus_rd),
      .wr          (bus_wr),
      .word        (bus_word),
      .ofs         (bus_addr[OFS_W-1:0]),
      .wdata_en    (bus_wdata[CFG_EN_BIT]),
      .head        (head),
      .level       (level),
      .full        (full),
      .empty       (empty),
      .push_drop   (push_drop),
      .peer_status (peer_status),
      .pop_req     (pop_req),
      .cfg_wr      (cfg_wr),
      .cfg_en      (cfg_en),
      .err         (err),
      .rdata       (bus_rdata),
      .irq         (irq)
   );

endmodule

// File: rtl/mbx_mailbox_chk.sv
module mbx_mailbox_chk #(
   parameter int unsigned  CNT_W   = 4,
   parameter logic [31:0]  INVALID = 32'hFFFF_FFFF
) (
   input logic             clk,
   input logic             rst_n,
   input logic             pop_req,
   input logic             push_ok,
   input logic             push_drop,
   input logic [CNT_W-1:0] level,
   input logic             full,
   input logic             empty,
   input logic [31:0]      head,
   input logic             cfg_en,
   input logic             cfg_wr,
   input logic             err_over,
   input logic             err_under,
   input logic             irq
);

   AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(full && empty)); // R3

   AST_HEAD_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
      empty |-> head == INVALID); // R4

   AST_EMPTY_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_req && empty && !push_ok) |=> empty); // R1

   AST_POP_SHRINK: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_req && !empty && !push_ok) |=> level == CNT_W'($past(level) - 1'b1)); // R5

   AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      irq == (cfg_en && !empty)); // R6

   AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && !push_drop && !(pop_req && empty)) |=> !err_over && !err_under); // R7

   AST_DROP_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      push_drop |-> full && !pop_req); // R8

   AST_DROP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      push_drop |=> err_over); // R8

endmodule

bind mbx_mailbox mbx_mailbox_chk #(
   .CNT_W   (CNT_W),
   .INVALID (INVALID)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .pop_req   (pop_req),
   .push_ok   (push_ok),
   .push_drop (push_drop),
   .level     (level),
   .full      (full),
   .empty     (empty),
   .head      (head),
   .cfg_en    (cfg_en),
   .cfg_wr    (cfg_wr),
   .err_over  (err.over),
   .err_under (err.under),
   .irq       (irq)
);

// File: tb/mbx_mailbox_test.sv
`timescale 1ns/1ps
module mbx_mailbox_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] bus_addr = '0;
   logic        bus_rd = 1'b0;
   logic        bus_wr = 1'b0;
   logic        bus_word = 1'b1;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        msg_push = 1'b0;
   logic [31:0] msg_data = '0;
   logic [31:0] peer_status = 32'h1234_5678;
   logic        irq;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   mbx_mailbox uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .bus_addr    (bus_addr),
      .bus_rd      (bus_rd),
      .bus_wr      (bus_wr),
      .bus_word    (bus_word),
      .bus_wdata   (bus_wdata),
      .bus_rdata   (bus_rdata),
      .msg_push    (msg_push),
      .msg_data    (msg_data),
      .peer_status (peer_status),
      .irq         (irq)
   );

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic rd32(logic [11:0] a, bit w, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1; bus_word = w;
      #1 d = bus_rdata;
      @(posedge clk);
      #1 bus_rd = 1'b0; bus_word = 1'b1;
   endtask

   task automatic wr32(logic [11:0] a, logic [31:0] v, bit w);
      @(negedge clk);
      bus_addr = a; bus_wdata = v; bus_wr = 1'b1; bus_word = w;
      @(posedge clk);
      #1 bus_wr = 1'b0; bus_word = 1'b1;
   endtask

   task automatic push(logic [31:0] v);
      @(negedge clk);
      msg_push = 1'b1; msg_data = v;
      @(posedge clk);
      #1 msg_push = 1'b0;
   endtask

   task automatic pop_and_push(logic [31:0] v, output logic [31:0] d);
      @(negedge clk);
      bus_addr = 12'h080; bus_rd = 1'b1; bus_word = 1'b1;
      msg_push = 1'b1; msg_data = v;
      #1 d = bus_rdata;
      @(posedge clk);
      #1 bus_rd = 1'b0; msg_push = 1'b0;
   endtask

   task automatic t_reset();
      logic [31:0] d;
      rd32(12'h098, 1, d); chk("R4 status after reset", d, 32'h4000_0000);
      rd32(12'h09C, 1, d); chk("R4 config after reset", d, 32'h0);
      rd32(12'h090, 1, d); chk("R4 peek after reset", d, 32'hFFFF_FFFF);
      chk("R4 irq after reset", {31'b0, irq}, 32'h0);
   endtask

   task automatic t_order();
      logic [31:0] d;
      push(32'hA1); push(32'hA2); push(32'hA3);
      rd32(12'h098, 1, d); chk("R3 level three", d, 32'h0000_0003);
      rd32(12'h090, 1, d); chk("R2 peek head", d, 32'hA1);
      rd32(12'h090, 1, d); chk("R2 peek again", d, 32'hA1);
      rd32(12'h098, 1, d); chk("R2 peek keeps level", d, 32'h0000_0003);
      rd32(12'h080, 1, d); chk("R1 pop first", d, 32'hA1);
      rd32(12'h084, 1, d); chk("R1 pop second", d, 32'hA2);
      rd32(12'h08C, 1, d); chk("R1 pop third", d, 32'hA3);
      rd32(12'h088, 1, d); chk("R1 empty read marker", d, 32'hFFFF_FFFF);
      rd32(12'h098, 1, d); chk("R1 empty read no change", d, 32'h4000_0000);
      rd32(12'h09C, 1, d); chk("R1 underflow flag", d, 32'h0000_0400);
   endtask

   task automatic t_cfg();
      logic [31:0] d;
      wr32(12'h09C, 32'hFFFF_FFFF, 1);
      rd32(12'h09C, 1, d); chk("R7 only enable kept, errors cleared", d, 32'h0000_0001);
      chk("R6 irq low when empty", {31'b0, irq}, 32'h0);
      push(32'hB0);
      chk("R6 irq high with data", {31'b0, irq}, 32'h1);
      rd32(12'h09C, 1, d); chk("R6 pending and enable", d, 32'h0000_0011);
      wr32(12'h09C, 32'h0, 1);
      chk("R6 irq low when disabled", {31'b0, irq}, 32'h0);
      rd32(12'h09C, 1, d); chk("R7 pending stays", d, 32'h0000_0010);
      rd32(12'h080, 1, d); chk("R1 pop B", d, 32'hB0);
   endtask

   task automatic t_full();
      logic [31:0] d;
      for (int i = 0; i < 8; i++) push(32'hC000_0000 + i);
      rd32(12'h098, 1, d); chk("R3 full status", d, 32'h8000_0008);
      push(32'hDEAD_BEEF);
      rd32(12'h09C, 1, d); chk("R8 overflow flag", d, 32'h0000_0210);
      rd32(12'h098, 1, d); chk("R8 drop keeps level", d, 32'h8000_0008);
      for (int i = 0; i < 8; i++) begin
         rd32(12'h080, 1, d); chk("R5 drain order", d, 32'hC000_0000 + i);
      end
      rd32(12'h090, 1, d); chk("R5 vacated slot invalid", d, 32'hFFFF_FFFF);
      rd32(12'h098, 1, d); chk("R3 empty after drain", d, 32'h4000_0000);
   endtask

   task automatic t_both();
      logic [31:0] d;
      wr32(12'h09C, 32'h0, 1);
      for (int i = 0; i < 8; i++) push(32'hD000_0000 + i);
      pop_and_push(32'hE0, d); chk("R8 pop while full", d, 32'hD000_0000);
      rd32(12'h098, 1, d); chk("R8 still full", d, 32'h8000_0008);
      rd32(12'h09C, 1, d); chk("R8 no overflow on pop+push", d, 32'h0000_0010);
      for (int i = 1; i < 8; i++) begin
         rd32(12'h080, 1, d); chk("R5 shifted order", d, 32'hD000_0000 + i);
      end
      rd32(12'h080, 1, d); chk("R5 pushed last", d, 32'hE0);
      pop_and_push(32'hF0, d); chk("R1 empty read with push", d, 32'hFFFF_FFFF);
      rd32(12'h098, 1, d); chk("R1 push kept", d, 32'h0000_0001);
      rd32(12'h09C, 1, d); chk("R1 underflow on empty pop", d, 32'h0000_0410);
      rd32(12'h080, 1, d); chk("R1 pop F", d, 32'hF0);
      wr32(12'h09C, 32'h0, 1);
   endtask

   task automatic t_decode();
      logic [31:0] d;
      rd32(12'h0B8, 1, d); chk("R9 peer status", d, 32'h1234_5678);
      rd32(12'hAB8, 1, d); chk("R9 peer status high bits", d, 32'h1234_5678);
      push(32'h66);
      rd32(12'h380, 1, d); chk("R9 pop through aliased address", d, 32'h66);
      rd32(12'h098, 1, d); chk("R9 aliased pop removed", d, 32'h4000_0000);
      rd32(12'h094, 1, d); chk("R10 unknown offset", d, 32'h0);
      rd32(12'h0C4, 1, d); chk("R10 unknown offset two", d, 32'h0);
      wr32(12'h0A0, 32'h1234, 1);
      rd32(12'h098, 1, d); chk("R10 write elsewhere ignored", d, 32'h4000_0000);
      push(32'h77);
      rd32(12'h080, 0, d); chk("R10 narrow read zero", d, 32'h0);
      rd32(12'h098, 1, d); chk("R10 narrow read keeps data", d, 32'h0000_0001);
      wr32(12'h09C, 32'h1, 0);
      rd32(12'h09C, 1, d); chk("R10 narrow write ignored", d, 32'h0000_0010);
      chk("R10 irq stays low", {31'b0, irq}, 32'h0);
      rd32(12'h080, 1, d); chk("R1 pop H", d, 32'h77);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_order();
      t_cfg();
      t_full();
      t_both();
      t_decode();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

endmodule